// File: doc/BRIEF.md
# Second-Level Page Accessed/Dirty Updater

This block sits next to the walker for second-level (guest-physical to host-physical) translation and decides, one walk step at a time, whether the 64-bit table entry just fetched needs its accessed or dirty flag set. For each step the walker presents the raw entry, the table level it came from, the kind of access (data write, guest page-table access, PAE page-directory-pointer register load) and the guest-physical page number. The global flag-update enable is sampled with the step.

One cycle after a step is accepted the block returns the entry as it should be in memory, a write-back request that is raised only when a flag actually moved from 0 to 1, and a one-cycle dirty-set pulse carrying the guest-physical page number, meant for a modification logger. With the enable low the block is transparent: the entry passes through and nothing is written back.

Top module: `gpa_flag_updater`

## Requirements
- R1: While rst_n is low, and after it until the first accepted step, out_valid, out_wb and dirty_pulse are 0.
- R2: A step presented with in_valid high at a rising edge gives out_valid high for exactly the following cycle; with in_valid low, out_valid is low the next cycle.
- R3: With ad_enable low at acceptance, out_entry equals the input entry bit for bit, and out_wb and dirty_pulse stay 0.
- R4: With ad_enable high, bit 8 (accessed) of out_entry is 1 for every step, whatever the level and access type.
- R5: An entry maps a page when in_level is 0 or entry bit 7 is 1. Bit 9 (dirty) is set only in such an entry, and only on an effective write; a non-mapping entry keeps bit 9 as it came in.
- R6: An effective write is in_write high or in_gpt_read high (a guest page-table access), provided in_pdpte_load is low; a guest page-table read on a mapping entry therefore sets bit 9.
- R7: When in_pdpte_load is high the step is a read: bit 9 is never set, even if in_write or in_gpt_read is high; bit 8 is still set.
- R8: Flags are sticky: no bit of the entry is ever cleared, and all bits other than 8 and 9 leave unchanged.
- R9: out_wb is 1 exactly when out_entry differs from the input entry, i.e. when at least one flag went from 0 to 1; an entry whose needed flags are already set gives no write-back.
- R10: dirty_pulse is high for one cycle exactly when bit 9 went from 0 to 1 for the step, and log_gpn then equals the in_gpn presented with that step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ad_enable | input | 1 | Global enable for flag updating |
| in_valid | input | 1 | Step presented this cycle |
| in_entry | input | ENTRY_W (64) | Table entry as read from memory |
| in_level | input | LVL_W (2) | Table level, 0 = last level |
| in_write | input | 1 | Access is a data write |
| in_gpt_read | input | 1 | Access is to a guest paging-structure entry |
| in_pdpte_load | input | 1 | Access is a PAE PDPTE register load |
| in_gpn | input | GPN_W (36) | Guest-physical page number of the access |
| out_valid | output | 1 | Result of the previous step is valid |
| out_entry | output | ENTRY_W (64) | Entry with flags applied |
| out_wb | output | 1 | Entry must be written back to memory |
| dirty_pulse | output | 1 | Dirty flag went from 0 to 1 |
| log_gpn | output | GPN_W (36) | Guest-physical page number for the logger |

## Verification
A wrong captured access type or level would show in the very next cycle as a dirty flag set in an intermediate entry, a missing dirty flag on a guest page-table access, or a dirty pulse on a register load. A stale or wrongly captured entry would show as a changed bit outside 8 and 9, or as out_wb disagreeing with whether out_entry differs from the entry presented one cycle before. Because the block has a single register stage, every fault is visible on the outputs in the cycle right after the step that exposes it, so each step is compared there against a bench model.

// File: rtl/gpaf_pkg.sv
// Package gpaf_pkg
// Shared constants and the per-step decision type of the accessed/dirty
// updater. Assumes 64-bit entries with the flag positions given below.
package gpaf_pkg;

    // Bit positions that the walker and memory format depend on
    localparam int unsigned ACC_BIT = 8;
    localparam int unsigned DRT_BIT = 9;
    localparam int unsigned MAP_BIT = 7;

    // Outcome of deciding one walk step
    typedef struct packed {
        logic maps_page;  // entry identifies the final physical address
        logic eff_write;  // access counts as a write for dirty tracking
        logic set_acc;    // accessed flag goes 0 -> 1
        logic set_drt;    // dirty flag goes 0 -> 1
    } decide_t;

endpackage

// File: rtl/gpaf_stage_reg.sv
// Module gpaf_stage_reg
// Single input register stage. Captures one walk step whenever in_valid is
// high and marks it valid for exactly the next cycle. Assumes the walker
// presents at most one step per cycle; no back-pressure exists.
module gpaf_stage_reg #(
    parameter int unsigned ENTRY_W = 64,
    parameter int unsigned LVL_W   = 2,
    parameter int unsigned GPN_W   = 36
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               ad_enable,
    input  logic [ENTRY_W-1:0] in_entry,
    input  logic [LVL_W-1:0]   in_level,
    input  logic               in_write,
    input  logic               in_gpt_read,
    input  logic               in_pdpte_load,
    input  logic [GPN_W-1:0]   in_gpn,
    output logic               q_valid,
    output logic               q_enable,
    output logic [ENTRY_W-1:0] q_entry,
    output logic [LVL_W-1:0]   q_level,
    output logic               q_write,
    output logic               q_gpt_read,
    output logic               q_pdpte_load,
    output logic [GPN_W-1:0]   q_gpn
);

    // Valid flag: follows in_valid, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) q_valid <= 1'b0;
        else        q_valid <= in_valid;
    end

    // Step payload: loaded only on an accepted step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_enable     <= 1'b0;
            q_entry      <= '0;
            q_level      <= '0;
            q_write      <= 1'b0;
            q_gpt_read   <= 1'b0;
            q_pdpte_load <= 1'b0;
            q_gpn        <= '0;
        end else if (in_valid) begin
            q_enable     <= ad_enable;
            q_entry      <= in_entry;
            q_level      <= in_level;
            q_write      <= in_write;
            q_gpt_read   <= in_gpt_read;
            q_pdpte_load <= in_pdpte_load;
            q_gpn        <= in_gpn;
        end
    end

endmodule

// File: rtl/gpaf_decide.sv
// Module gpaf_decide
// Combinational decision for one registered step: does the entry map a
// page, does the access count as a write, and which flags must rise.
// Assumes level 0 is the last table level.
module gpaf_decide
    import gpaf_pkg::*;
#(
    parameter int unsigned ENTRY_W = 64,
    parameter int unsigned LVL_W   = 2
) (
    input  logic               valid,
    input  logic               enable,
    input  logic [ENTRY_W-1:0] entry,
    input  logic [LVL_W-1:0]   level,
    input  logic               is_write,
    input  logic               is_gpt_read,
    input  logic               is_pdpte_load,
    output decide_t            dec
);

    logic active;

    // Step is only acted on when it is valid and updating is enabled
    always_comb active = valid & enable;

    // Classify the step and compute which flags rise from 0 to 1
    always_comb begin
        dec.maps_page = (level == '0) | entry[MAP_BIT];
        dec.eff_write = ~is_pdpte_load & (is_write | is_gpt_read);
        dec.set_acc   = active & ~entry[ACC_BIT];
        dec.set_drt   = active & dec.maps_page & dec.eff_write & ~entry[DRT_BIT];
    end

endmodule

// File: rtl/gpaf_merge.sv
// Module gpaf_merge
// Applies the decided flag sets to the entry. Only bits ACC_BIT and
// DRT_BIT can change and only towards 1; every other bit is copied.
module gpaf_merge
    import gpaf_pkg::*;
#(
    parameter int unsigned ENTRY_W = 64
) (
    input  logic               valid,
    input  logic [ENTRY_W-1:0] entry,
    input  decide_t            dec,
    output logic [ENTRY_W-1:0] new_entry,
    output logic               wb,
    output logic               drt_rise
);

    // Per-bit merge: OR in the flag set on the two flag positions
    for (genvar b = 0; b < ENTRY_W; b++) begin : g_bit
        if (b == ACC_BIT) begin : g_acc
            always_comb new_entry[b] = entry[b] | dec.set_acc;
        end else if (b == DRT_BIT) begin : g_drt
            always_comb new_entry[b] = entry[b] | dec.set_drt;
        end else begin : g_copy
            always_comb new_entry[b] = entry[b];
        end
    end

    // Write-back and dirty-rise strobes, gated by the valid cycle
    always_comb begin
        wb       = valid & (dec.set_acc | dec.set_drt);
        drt_rise = valid & dec.set_drt;
    end

endmodule

// File: rtl/gpa_flag_updater.sv
// Module gpa_flag_updater
// Accessed/dirty flag updater for second-level table walk steps. One
// register stage, then combinational decision and merge; the result is
// valid the cycle after the step is accepted. Assumes the walker supplies
// the level and access type and writes the entry back itself on out_wb.
module gpa_flag_updater
    import gpaf_pkg::*;
#(
    parameter int unsigned ENTRY_W = 64,
    parameter int unsigned LVL_W   = 2,
    parameter int unsigned GPN_W   = 36
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ad_enable,
    input  logic               in_valid,
    input  logic [ENTRY_W-1:0] in_entry,
    input  logic [LVL_W-1:0]   in_level,
    input  logic               in_write,
    input  logic               in_gpt_read,
    input  logic               in_pdpte_load,
    input  logic [GPN_W-1:0]   in_gpn,
    output logic               out_valid,
    output logic [ENTRY_W-1:0] out_entry,
    output logic               out_wb,
    output logic               dirty_pulse,
    output logic [GPN_W-1:0]   log_gpn
);

    logic               q_valid, q_enable, q_write, q_gpt_read, q_pdpte_load;
    logic [ENTRY_W-1:0] q_entry;
    logic [LVL_W-1:0]   q_level;
    logic [GPN_W-1:0]   q_gpn;
    decide_t            dec;

    gpaf_stage_reg #(.ENTRY_W(ENTRY_W), .LVL_W(LVL_W), .GPN_W(GPN_W)) u_stage (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .ad_enable    (ad_enable),
        .in_entry     (in_entry),
        .in_level     (in_level),
        .in_write     (in_write),
        .in_gpt_read  (in_gpt_read),
        .in_pdpte_load(in_pdpte_load),
        .in_gpn       (in_gpn),
        .q_valid      (q_valid),
        .q_enable     (q_enable),
        .q_entry      (q_entry),
        .q_level      (q_level),
        .q_write      (q_write),
        .q_gpt_read   (q_gpt_read),
        .q_pdpte_load (q_pdpte_load),
        .q_gpn        (q_gpn)
    );

    gpaf_decide #(.ENTRY_W(ENTRY_W), .LVL_W(LVL_W)) u_decide (
        .valid        (q_valid),
        .enable       (q_enable),
        .entry        (q_entry),
        .level        (q_level),
        .is_write     (q_write),
        .is_gpt_read  (q_gpt_read),
        .is_pdpte_load(q_pdpte_load),
        .dec          (dec)
    );

    gpaf_merge #(.ENTRY_W(ENTRY_W)) u_merge (
        .valid    (q_valid),
        .entry    (q_entry),
        .dec      (dec),
        .new_entry(out_entry),
        .wb       (out_wb),
        .drt_rise (dirty_pulse)
    );

    // Output valid and logger page number come straight from the stage
    always_comb begin
        out_valid = q_valid;
        log_gpn   = q_gpn;
    end

endmodule

// File: rtl/gpaf_checker.sv
// Module gpaf_checker
// Port-level properties of gpa_flag_updater, bound to every instance.
module gpaf_checker #(
    parameter int unsigned ENTRY_W = 64,
    parameter int unsigned LVL_W   = 2,
    parameter int unsigned GPN_W   = 36
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ad_enable,
    input logic               in_valid,
    input logic [ENTRY_W-1:0] in_entry,
    input logic [LVL_W-1:0]   in_level,
    input logic               in_write,
    input logic               in_gpt_read,
    input logic               in_pdpte_load,
    input logic [GPN_W-1:0]   in_gpn,
    input logic               out_valid,
    input logic [ENTRY_W-1:0] out_entry,
    input logic               out_wb,
    input logic               dirty_pulse,
    input logic [GPN_W-1:0]   log_gpn
);

    localparam logic [ENTRY_W-1:0] FLAG_MASK = (ENTRY_W'(1) << 8) | (ENTRY_W'(1) << 9);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_wb && !dirty_pulse));

    // R2
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R3
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !ad_enable) |=>
            (out_entry == $past(in_entry) && !out_wb && !dirty_pulse));

    // R4
    accessed_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ad_enable) |=> out_entry[8]);

    // R5
    no_dirty_midlevel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_level != '0 && !in_entry[7]) |=> !dirty_pulse);

    // R6
    gpt_read_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ad_enable && in_level == '0 && in_gpt_read && !in_write &&
         !in_pdpte_load && !in_entry[9]) |=> dirty_pulse);

    // R5
    write_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ad_enable && in_entry[7] && in_write &&
         !in_pdpte_load && !in_entry[9]) |=> (dirty_pulse && out_entry[9]));

    // R7
    pdpte_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_pdpte_load) |=> !dirty_pulse);

    // R8
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (((out_entry ^ $past(in_entry)) & ~FLAG_MASK) == '0 &&
                      (out_entry & $past(in_entry)) == $past(in_entry)));

    // R9
    wb_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_wb == (out_entry != $past(in_entry))));

    // R10
    pulse_gpn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (!dirty_pulse || (log_gpn == $past(in_gpn) && !$past(in_entry[9]))));

    // R10
    pulse_implies_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dirty_pulse |-> (out_wb && out_entry[9]));

endmodule

bind gpa_flag_updater gpaf_checker #(.ENTRY_W(ENTRY_W), .LVL_W(LVL_W), .GPN_W(GPN_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ad_enable    (ad_enable),
    .in_valid     (in_valid),
    .in_entry     (in_entry),
    .in_level     (in_level),
    .in_write     (in_write),
    .in_gpt_read  (in_gpt_read),
    .in_pdpte_load(in_pdpte_load),
    .in_gpn       (in_gpn),
    .out_valid    (out_valid),
    .out_entry    (out_entry),
    .out_wb       (out_wb),
    .dirty_pulse  (dirty_pulse),
    .log_gpn      (log_gpn)
);

// File: tb/gpa_flag_updater_test.sv
// Bench for gpa_flag_updater: directed corners plus seeded random steps,
// each compared with a model computed from the requirements.
module gpa_flag_updater_test;

    localparam int unsigned ENTRY_W = 64;
    localparam int unsigned LVL_W   = 2;
    localparam int unsigned GPN_W   = 36;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               ad_enable = 1'b0;
    logic               in_valid = 1'b0;
    logic [ENTRY_W-1:0] in_entry = '0;
    logic [LVL_W-1:0]   in_level = '0;
    logic               in_write = 1'b0;
    logic               in_gpt_read = 1'b0;
    logic               in_pdpte_load = 1'b0;
    logic [GPN_W-1:0]   in_gpn = '0;
    logic               out_valid;
    logic [ENTRY_W-1:0] out_entry;
    logic               out_wb;
    logic               dirty_pulse;
    logic [GPN_W-1:0]   log_gpn;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    gpa_flag_updater #(.ENTRY_W(ENTRY_W), .LVL_W(LVL_W), .GPN_W(GPN_W)) uut (.*);

    // Model of the updated entry from the requirements (R3..R8)
    function automatic logic [ENTRY_W-1:0] model_entry(
        input logic en, input logic [ENTRY_W-1:0] e, input logic [LVL_W-1:0] lvl,
        input logic wr, input logic gpt, input logic pdl);
        logic [ENTRY_W-1:0] r;
        logic mapping, write_like;
        r = e;
        mapping    = (lvl == 0) || e[7];
        write_like = !pdl && (wr || gpt);
        if (en) begin
            r[8] = 1'b1;
            if (mapping && write_like) r[9] = 1'b1;
        end
        return r;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [ENTRY_W-1:0] act, input logic [ENTRY_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Present one step on a falling edge, check the result one cycle later
    task automatic step(input logic en, input logic [ENTRY_W-1:0] e,
                        input logic [LVL_W-1:0] lvl, input logic wr,
                        input logic gpt, input logic pdl, input logic [GPN_W-1:0] gpn);
        logic [ENTRY_W-1:0] exp_e;
        logic exp_wb, exp_dp;
        @(negedge clk);
        ad_enable = en; in_valid = 1'b1; in_entry = e; in_level = lvl;
        in_write = wr; in_gpt_read = gpt; in_pdpte_load = pdl; in_gpn = gpn;
        @(negedge clk);
        in_valid = 1'b0;
        exp_e  = model_entry(en, e, lvl, wr, gpt, pdl);
        exp_wb = (exp_e != e);
        exp_dp = exp_e[9] && !e[9];
        check("R2", "out_valid", 64'(out_valid), 64'(1'b1));
        check("R8", "out_entry", out_entry, exp_e);
        check("R9", "out_wb", 64'(out_wb), 64'(exp_wb));
        check("R10", "dirty_pulse", 64'(dirty_pulse), 64'(exp_dp));
        if (exp_dp) check("R10", "log_gpn", 64'(log_gpn), 64'(gpn));
    endtask

    initial begin
        logic [ENTRY_W-1:0] base;
        base = 64'h0000_1234_5678_F0A5 & ~64'h380; // bits 7,8,9 clear
        void'($urandom(32'h5EED_0042));
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", "out_valid in reset", 64'(out_valid), 64'h0);
        check("R1", "out_wb in reset", 64'(out_wb), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "out_valid after reset", 64'(out_valid), 64'h0);
        check("R1", "dirty_pulse after reset", 64'(dirty_pulse), 64'h0);

        // R3: enable low, write on leaf passes through
        step(1'b0, base, 2'd0, 1'b1, 1'b0, 1'b0, 36'h1);
        check("R3", "wb with enable low", 64'(out_wb), 64'h0);
        // R4: read on intermediate level sets only accessed
        step(1'b1, base, 2'd2, 1'b0, 1'b0, 1'b0, 36'h2);
        check("R4", "accessed bit", 64'(out_entry[8]), 64'h1);
        // R5: write on intermediate level, no dirty
        step(1'b1, base, 2'd1, 1'b1, 1'b0, 1'b0, 36'h3);
        check("R5", "dirty on intermediate", 64'(out_entry[9]), 64'h0);
        // R5: write on large page (bit 7) at level 2 sets dirty
        step(1'b1, base | 64'h80, 2'd2, 1'b1, 1'b0, 1'b0, 36'hA_BCDE_F012);
        check("R5", "dirty on large page", 64'(out_entry[9]), 64'h1);
        // R6: guest page-table read on last level sets dirty
        step(1'b1, base, 2'd0, 1'b0, 1'b1, 1'b0, 36'h5);
        check("R6", "dirty on gpt read", 64'(out_entry[9]), 64'h1);
        // R7: PDPTE load with write and gpt set still leaves dirty clear
        step(1'b1, base, 2'd0, 1'b1, 1'b1, 1'b1, 36'h6);
        check("R7", "dirty on pdpte load", 64'(out_entry[9]), 64'h0);
        check("R7", "accessed on pdpte load", 64'(out_entry[8]), 64'h1);
        // R9: flags already set, write gives no write-back
        step(1'b1, base | 64'h300, 2'd0, 1'b1, 1'b0, 1'b0, 36'h7);
        check("R9", "wb with flags set", 64'(out_wb), 64'h0);
        // R2: idle cycle after a step
        @(negedge clk);
        check("R2", "out_valid idle", 64'(out_valid), 64'h0);

        // Seeded random steps, back to back and with gaps
        for (int i = 0; i < 400; i++) begin
            logic [ENTRY_W-1:0] e;
            e = {$urandom(), $urandom()};
            if ($urandom_range(0, 1) == 0) e[8] = 1'b0;
            if ($urandom_range(0, 1) == 0) e[9] = 1'b0;
            step(1'($urandom_range(0, 3) != 0), e, LVL_W'($urandom_range(0, 3)),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 4) == 0), {4'($urandom()), 32'($urandom())});
            if ($urandom_range(0, 3) == 0) begin
                @(negedge clk);
                check("R2", "out_valid gap", 64'(out_valid), 64'h0);
                check("R10", "dirty_pulse gap", 64'(dirty_pulse), 64'h0);
            end
        end
        done = 1'b1;
    end

    // Watchdog and summary
    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule